// File: doc/BRIEF.md
# I2C Master Command-Queue Sequencer

This block runs an I2C master transaction from a small table of command words that the host fills in ahead of time. Each entry names one step: a (repeated) START, a WRITE or READ of a given number of bytes, a STOP, or an END. Each entry also carries the acknowledge controls for that step. After a start pulse, the sequencer walks the entries from index 0 upward. For each byte it hands one request to a separate bit engine, which generates the actual SCL/SDA waveforms. Write bytes come from a transmit FIFO that the host preloads, with the address byte(s) ahead of the payload. Read bytes go into a receive FIFO that the host drains afterwards.

When an entry finishes, the hardware sets that entry's done flag. A STOP entry releases the bus and ends the run. An END entry ends the run but keeps the bus held. The host can then rewrite the table and pulse start again; execution continues from entry 0 with no STOP/START in between. A run also ends early on an acknowledge mismatch, on a programmable response timeout, or when the bit engine reports lost arbitration. Each of these events latches a sticky interrupt bit, and the host clears the bits by writing ones.

Top module: `i2cq_top`

## Requirements
- R1: After reset the block is idle: busy, bus_held, irq, int_raw, int_stat, tx_level and rx_level are all 0.
- R2: A command word has this layout: bits [7:0] byte count, bit 8 ack-check enable, bit 9 expected ack level, bit 10 ack level driven after read bytes, bits [13:11] opcode, bit 31 done flag. The hardware sets bit 31 of each entry that completes, and leaves it clear on entries that are not reached.
- R3: Opcode 1 (WRITE) issues count requests with eng_op=1. Each request carries the next transmit FIFO byte in FIFO order, and the byte is popped when the engine reports done. Opcode 0 (START) issues eng_op=0 and sets bus_held.
- R4: Opcode 2 (READ) issues count requests with eng_op=2 and eng_ack_drive equal to the entry's bit 10. Each returned byte is pushed into the receive FIFO in order.
- R5: On a WRITE byte with ack-check enabled, if eng_ack_in differs from the expected level, the run stops at once. int_raw bit 1 is set, that entry's done flag stays clear, and bus_held is unchanged.
- R6: With ack-check disabled, the received ack level has no effect on a WRITE.
- R7: Opcode 3 (STOP) issues eng_op=3, clears bus_held, sets its done flag and int_raw bit 0, and ends the run. Opcode 4 (END) makes no request, sets its done flag and int_raw bit 0, and leaves bus_held unchanged. A later start pulse begins again at entry 0. Opcodes 5 to 7 act as END, and completing entry 15 ends the run with int_raw bit 0.
- R8: A WRITE or READ entry with count 0 makes no engine request and completes at once.
- R9: If the engine gives no response within cfg_timeout+1 cycles of a request, the run stops. int_raw bit 2 is set and bus_held is cleared.
- R10: An eng_arb_lost pulse during a request stops the run, sets int_raw bit 3 and clears bus_held.
- R11: int_raw bits stay set until a 1 is written to the same bit of int_clr. int_stat equals int_raw AND int_en, and irq is the OR of int_stat.
- R12: While fifo_rst is high, both FIFOs are emptied (tx_level and rx_level become 0 on the next cycle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_we | input | 1 | Command entry write strobe |
| slot_waddr | input | 4 | Entry index to write |
| slot_wdata | input | 32 | Command word to write |
| slot_raddr | input | 4 | Entry index to read |
| slot_rdata | output | 32 | Command word at slot_raddr, done flag included |
| start | input | 1 | Start pulse, ignored while busy |
| busy | output | 1 | A run is in progress |
| bus_held | output | 1 | Bus owned since a START, not yet released |
| tx_push | input | 1 | Push tx_wdata into the transmit FIFO |
| tx_wdata | input | 8 | Transmit byte |
| tx_level | output | 6 | Transmit FIFO fill level |
| rx_pop | input | 1 | Pop the receive FIFO head |
| rx_rdata | output | 8 | Receive FIFO head |
| rx_level | output | 6 | Receive FIFO fill level |
| fifo_rst | input | 1 | Empties both FIFOs |
| cfg_timeout | input | 16 | Response timeout in cycles |
| int_en | input | 4 | Interrupt enable mask |
| int_clr | input | 4 | Write-one-to-clear of int_raw |
| int_raw | output | 4 | Raw events: 0 complete, 1 ack error, 2 timeout, 3 arbitration lost |
| int_stat | output | 4 | Enabled events |
| irq | output | 1 | Interrupt request |
| eng_req | output | 1 | Byte-level request to the bit engine |
| eng_op | output | 2 | Request kind: 0 start, 1 write, 2 read, 3 stop |
| eng_wdata | output | 8 | Byte to send on a write |
| eng_ack_drive | output | 1 | Ack level to drive after a read byte |
| eng_done | input | 1 | Engine finished the current request |
| eng_ack_in | input | 1 | Ack level received on a write |
| eng_rdata | input | 8 | Byte received on a read |
| eng_arb_lost | input | 1 | Engine lost arbitration |

## Verification
A wrong entry pointer or byte counter shows up at the engine port within one request: the sequence of eng_op values and bytes no longer matches the table and FIFO contents. A done flag set or missed in error is visible on slot_rdata as soon as the run ends. A wrong abort path shows in the same cycle that busy falls, through an unexpected int_raw bit or bus_held value. Receive-path faults show as wrong bytes or a wrong count when the receive FIFO is drained.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
  localparam int OPC_LSB = 11;
  localparam int OPC_W   = 3;
  localparam int CNT_W   = 8;
  localparam int BIT_ACK_CHK  = 8;
  localparam int BIT_ACK_EXP  = 9;
  localparam int BIT_ACK_DRV  = 10;
  localparam int BIT_DONE     = 31;

  typedef enum logic [OPC_W-1:0] {
    OPC_START = 3'd0,
    OPC_WRITE = 3'd1,
    OPC_READ  = 3'd2,
    OPC_STOP  = 3'd3,
    OPC_END   = 3'd4
  } opc_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_EXEC  = 2'd2
  } seq_st_e;

  localparam int EV_DONE = 0;
  localparam int EV_ACK  = 1;
  localparam int EV_TO   = 2;
  localparam int EV_ARB  = 3;
  localparam int EV_W    = 4;
endpackage

// File: rtl/i2cq_rstsync.sv
module i2cq_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], 1'b1};
  end
  assign rst_n_sync = sh[STAGES-1];
endmodule

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH+1);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp, wp_n, rp_n;
  logic [LW-1:0] cnt, cnt_n;
  logic do_push, do_pop;

  assign do_push = push && (cnt != FULL);
  assign do_pop  = pop  && (cnt != '0);

  always_comb begin
    wp_n  = wp;
    rp_n  = rp;
    cnt_n = cnt;
    if (clr) begin
      wp_n  = '0;
      rp_n  = '0;
      cnt_n = '0;
    end else begin
      if (do_push) wp_n = wp + 1'b1;
      if (do_pop)  rp_n = rp + 1'b1;
      cnt_n = cnt + LW'(do_push) - LW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      wp  <= wp_n;
      rp  <= rp_n;
      cnt <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp] <= din;
  end

  assign dout  = mem[rp];
  assign level = cnt;
endmodule

// File: rtl/i2cq_irq.sv
module i2cq_irq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] raw,
  output logic [N-1:0] stat,
  output logic         irq
);
  logic [N-1:0] raw_n;
  // a new event in the same cycle as its clear wins
  assign raw_n = (raw & ~clr) | set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw <= '0;
    else        raw <= raw_n;
  end

  assign stat = raw & en;
  assign irq  = |stat;
endmodule

// File: rtl/i2cq_seq.sv
module i2cq_seq
  import i2cq_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int TO_W      = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         slot_we,
  input  logic [$clog2(NUM_SLOTS)-1:0] slot_waddr,
  input  logic [31:0]                  slot_wdata,
  input  logic [$clog2(NUM_SLOTS)-1:0] slot_raddr,
  output logic [31:0]                  slot_rdata,
  input  logic                         start,
  input  logic [TO_W-1:0]              cfg_timeout,
  output logic                         busy,
  output logic                         bus_held,
  input  logic [7:0]                   tx_head,
  output logic                         tx_pop,
  output logic                         rx_push,
  output logic                         eng_req,
  output logic [1:0]                   eng_op,
  output logic                         eng_ack_drive,
  input  logic                         eng_done,
  input  logic                         eng_ack_in,
  input  logic                         eng_arb_lost,
  output logic [EV_W-1:0]              ev
);
  localparam int IW = $clog2(NUM_SLOTS);
  localparam logic [IW-1:0] LAST = IW'(NUM_SLOTS-1);

  logic [31:0]      slots [NUM_SLOTS];
  seq_st_e          st, st_n;
  logic [IW-1:0]    ptr, ptr_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [TO_W-1:0]  tcnt, tcnt_n;
  logic             held_n, finish, mark_done;
  logic [31:0]      cur;
  logic [OPC_W-1:0] op;

  assign cur = slots[ptr];
  assign op  = cur[OPC_LSB +: OPC_W];

  always_comb begin
    st_n      = st;
    ptr_n     = ptr;
    cnt_n     = cnt;
    tcnt_n    = tcnt;
    held_n    = bus_held;
    finish    = 1'b0;
    mark_done = 1'b0;
    ev        = '0;
    tx_pop    = 1'b0;
    rx_push   = 1'b0;
    case (st)
      ST_IDLE: if (start) begin
        ptr_n = '0;
        st_n  = ST_FETCH;
      end
      ST_FETCH: begin
        tcnt_n = '0;
        cnt_n  = cur[CNT_W-1:0];
        case (op)
          OPC_START, OPC_STOP: st_n = ST_EXEC;
          OPC_WRITE, OPC_READ:
            if (cur[CNT_W-1:0] == '0) finish = 1'b1;
            else                      st_n   = ST_EXEC;
          default: begin
            mark_done   = 1'b1;
            ev[EV_DONE] = 1'b1;
            st_n        = ST_IDLE;
          end
        endcase
      end
      ST_EXEC: begin
        if (eng_arb_lost) begin
          ev[EV_ARB] = 1'b1;
          held_n     = 1'b0;
          st_n       = ST_IDLE;
        end else if (eng_done) begin
          tcnt_n = '0;
          case (op)
            OPC_START: begin
              held_n = 1'b1;
              finish = 1'b1;
            end
            OPC_STOP: begin
              held_n      = 1'b0;
              mark_done   = 1'b1;
              ev[EV_DONE] = 1'b1;
              st_n        = ST_IDLE;
            end
            OPC_WRITE: begin
              tx_pop = 1'b1;
              if (cur[BIT_ACK_CHK] && (eng_ack_in != cur[BIT_ACK_EXP])) begin
                ev[EV_ACK] = 1'b1;
                st_n       = ST_IDLE;
              end else begin
                cnt_n = cnt - 1'b1;
                if (cnt == CNT_W'(1)) finish = 1'b1;
              end
            end
            default: begin
              rx_push = 1'b1;
              cnt_n   = cnt - 1'b1;
              if (cnt == CNT_W'(1)) finish = 1'b1;
            end
          endcase
        end else if (tcnt == cfg_timeout) begin
          ev[EV_TO] = 1'b1;
          held_n    = 1'b0;
          st_n      = ST_IDLE;
        end else begin
          tcnt_n = tcnt + 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
    if (finish) begin
      mark_done = 1'b1;
      if (ptr == LAST) begin
        ev[EV_DONE] = 1'b1;
        st_n        = ST_IDLE;
      end else begin
        ptr_n = ptr + 1'b1;
        st_n  = ST_FETCH;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      ptr      <= '0;
      cnt      <= '0;
      tcnt     <= '0;
      bus_held <= 1'b0;
    end else begin
      st       <= st_n;
      ptr      <= ptr_n;
      cnt      <= cnt_n;
      tcnt     <= tcnt_n;
      bus_held <= held_n;
    end
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic host_wr, hw_done;
    assign host_wr = slot_we && (slot_waddr == IW'(i));
    assign hw_done = mark_done && (ptr == IW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slots[i] <= '0;
      else if (host_wr) slots[i] <= slot_wdata;
      else if (hw_done) slots[i][BIT_DONE] <= 1'b1;
    end
  end

  assign slot_rdata    = slots[slot_raddr];
  assign busy          = (st != ST_IDLE);
  assign eng_req       = (st == ST_EXEC);
  assign eng_op        = op[1:0];
  assign eng_ack_drive = cur[BIT_ACK_DRV];
  logic unused_head;
  assign unused_head = ^tx_head;
endmodule

// File: rtl/i2cq_top.sv
module i2cq_top
  import i2cq_pkg::*;
#(
  parameter int NUM_SLOTS  = 16,
  parameter int FIFO_DEPTH = 32,
  parameter int TO_W       = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            slot_we,
  input  logic [$clog2(NUM_SLOTS)-1:0]    slot_waddr,
  input  logic [31:0]                     slot_wdata,
  input  logic [$clog2(NUM_SLOTS)-1:0]    slot_raddr,
  output logic [31:0]                     slot_rdata,
  input  logic                            start,
  output logic                            busy,
  output logic                            bus_held,
  input  logic                            tx_push,
  input  logic [7:0]                      tx_wdata,
  output logic [$clog2(FIFO_DEPTH+1)-1:0] tx_level,
  input  logic                            rx_pop,
  output logic [7:0]                      rx_rdata,
  output logic [$clog2(FIFO_DEPTH+1)-1:0] rx_level,
  input  logic                            fifo_rst,
  input  logic [TO_W-1:0]                 cfg_timeout,
  input  logic [3:0]                      int_en,
  input  logic [3:0]                      int_clr,
  output logic [3:0]                      int_raw,
  output logic [3:0]                      int_stat,
  output logic                            irq,
  output logic                            eng_req,
  output logic [1:0]                      eng_op,
  output logic [7:0]                      eng_wdata,
  output logic                            eng_ack_drive,
  input  logic                            eng_done,
  input  logic                            eng_ack_in,
  input  logic [7:0]                      eng_rdata,
  input  logic                            eng_arb_lost
);
  logic rst_s, tx_pop, rx_push;
  logic [EV_W-1:0] ev;

  i2cq_rstsync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s));

  i2cq_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txf (
    .clk(clk), .rst_n(rst_s), .clr(fifo_rst), .push(tx_push), .din(tx_wdata),
    .pop(tx_pop), .dout(eng_wdata), .level(tx_level));

  i2cq_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxf (
    .clk(clk), .rst_n(rst_s), .clr(fifo_rst), .push(rx_push), .din(eng_rdata),
    .pop(rx_pop), .dout(rx_rdata), .level(rx_level));

  i2cq_seq #(.NUM_SLOTS(NUM_SLOTS), .TO_W(TO_W)) u_seq (
    .clk(clk), .rst_n(rst_s), .slot_we(slot_we), .slot_waddr(slot_waddr),
    .slot_wdata(slot_wdata), .slot_raddr(slot_raddr), .slot_rdata(slot_rdata),
    .start(start), .cfg_timeout(cfg_timeout), .busy(busy), .bus_held(bus_held),
    .tx_head(eng_wdata), .tx_pop(tx_pop), .rx_push(rx_push), .eng_req(eng_req),
    .eng_op(eng_op), .eng_ack_drive(eng_ack_drive), .eng_done(eng_done),
    .eng_ack_in(eng_ack_in), .eng_arb_lost(eng_arb_lost), .ev(ev));

  i2cq_irq #(.N(EV_W)) u_irq (
    .clk(clk), .rst_n(rst_s), .set(ev), .clr(int_clr), .en(int_en),
    .raw(int_raw), .stat(int_stat), .irq(irq));
endmodule

// File: rtl/i2cq_chk.sv
module i2cq_chk #(
  parameter int LW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          bus_held,
  input logic [3:0]    int_raw,
  input logic [3:0]    int_clr,
  input logic          fifo_rst,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level
);
  assert_done_ends_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_raw[0]) |-> !busy);
  assert_ackerr_keeps_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_raw[1]) |-> (!busy && (bus_held == $past(bus_held))));
  assert_timeout_frees_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_raw[2]) |-> (!busy && !bus_held));
  assert_arb_frees_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_raw[3]) |-> (!busy && !bus_held));
  assert_raw_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((int_raw & $past(int_raw & ~int_clr)) == $past(int_raw & ~int_clr)));
  assert_fifo_flush_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rst |=> (tx_level == '0 && rx_level == '0));
endmodule

bind i2cq_top i2cq_chk #(.LW($clog2(FIFO_DEPTH+1))) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .bus_held(bus_held), .int_raw(int_raw),
  .int_clr(int_clr), .fifo_rst(fifo_rst), .tx_level(tx_level), .rx_level(rx_level));

// File: tb/tb_i2cq_top.sv
`timescale 1ns/1ps
module tb_i2cq_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic slot_we = 0; logic [3:0] slot_waddr = 0; logic [31:0] slot_wdata = 0;
  logic [3:0] slot_raddr = 0; logic [31:0] slot_rdata;
  logic start = 0, busy, bus_held;
  logic tx_push = 0; logic [7:0] tx_wdata = 0; logic [5:0] tx_level;
  logic rx_pop = 0; logic [7:0] rx_rdata; logic [5:0] rx_level;
  logic fifo_rst = 0; logic [15:0] cfg_timeout = 16'd200;
  logic [3:0] int_en = 4'hF, int_clr = 0, int_raw, int_stat;
  logic irq, eng_req, eng_ack_drive;
  logic [1:0] eng_op; logic [7:0] eng_wdata;
  logic eng_done, eng_ack_in, eng_arb_lost; logic [7:0] eng_rdata;

  i2cq_top dut (.*);

  int tests = 0, fails = 0;
  int lat = 2, arb_at = -1, log_n = 0, wcnt = 0;
  bit hang = 0, ack_level = 0;
  logic [1:0] log_op [1024];
  logic [7:0] log_data [1024];
  logic       log_ackd [1024];

  function automatic logic [7:0] rd_byte(int n);
    return 8'((n * 37 + 11) & 255);
  endfunction
  function automatic logic [31:0] mk(int op, int cnt, bit ae, bit ax, bit av);
    return {18'd0, 3'(op), av, ax, ae, 8'(cnt)};
  endfunction

  // bit engine model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_done <= 0; eng_arb_lost <= 0; eng_ack_in <= 0; eng_rdata <= 0; wcnt <= 0;
    end else begin
      eng_done <= 0; eng_arb_lost <= 0;
      if (eng_req && !eng_done && !eng_arb_lost && !hang) begin
        if (wcnt >= lat) begin
          wcnt <= 0;
          if (log_n == arb_at) eng_arb_lost <= 1;
          else begin
            eng_done <= 1; eng_rdata <= rd_byte(log_n); eng_ack_in <= ack_level;
          end
          log_op[log_n % 1024] <= eng_op;
          log_data[log_n % 1024] <= eng_wdata;
          log_ackd[log_n % 1024] <= eng_ack_drive;
          log_n <= log_n + 1;
        end else wcnt <= wcnt + 1;
      end
    end
  end

  task automatic chk(string req, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask
  task automatic wslot(int i, logic [31:0] w);
    @(negedge clk); slot_we = 1; slot_waddr = 4'(i); slot_wdata = w;
    @(negedge clk); slot_we = 0;
  endtask
  task automatic push(logic [7:0] b);
    @(negedge clk); tx_push = 1; tx_wdata = b;
    @(negedge clk); tx_push = 0;
  endtask
  task automatic clr_all();
    @(negedge clk); int_clr = 4'hF; fifo_rst = 1;
    @(negedge clk); int_clr = 0; fifo_rst = 0;
  endtask
  function automatic bit dflag(int i);
    return 1'b0;
  endfunction
  task automatic done_of(int i, output bit d);
    slot_raddr = 4'(i); #1; d = slot_rdata[31];
  endtask
  task automatic run();
    int k = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    while (busy && k < 5000) begin @(negedge clk); k++; end
    if (busy) begin tests++; fails++; $display("FAIL run: busy stuck actual 1 expected 0"); end
  endtask
  task automatic pop_byte(output logic [7:0] b);
    @(negedge clk); b = rx_rdata; rx_pop = 1;
    @(negedge clk); rx_pop = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int base, errs, n;
    bit d;
    logic [7:0] b;
    logic [7:0] exp [32];
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0); chk("R1 bus_held", bus_held, 0); chk("R1 irq", irq, 0);
    chk("R1 int_raw", int_raw, 0); chk("R1 int_stat", int_stat, 0);
    chk("R1 levels", {tx_level, rx_level}, 0);

    // R3/R7 write transaction ending in STOP
    base = log_n;
    wslot(0, mk(0,0,0,0,0)); wslot(1, mk(1,3,1,0,0)); wslot(2, mk(3,0,0,0,0));
    wslot(3, mk(4,0,0,0,0));
    push(8'h50); push(8'hC3); push(8'h7E);
    run();
    chk("R3 request count", log_n - base, 5);
    chk("R3 start op", log_op[base], 0);
    chk("R3 write bytes", {log_op[base+1], log_data[base+1], log_op[base+2], log_data[base+2],
        log_op[base+3], log_data[base+3]}, {2'd1, 8'h50, 2'd1, 8'hC3, 2'd1, 8'h7E});
    chk("R7 stop op", log_op[base+4], 3);
    chk("R7 complete raw", int_raw, 4'b0001);
    chk("R7 stop releases bus", bus_held, 0);
    chk("R3 tx drained", tx_level, 0);
    done_of(0, d); chk("R2 done slot0", d, 1);
    done_of(2, d); chk("R2 done slot2", d, 1);
    done_of(3, d); chk("R2 unreached slot3", d, 0);
    chk("R11 stat/irq", {int_stat, irq}, {4'b0001, 1'b1});
    @(negedge clk); int_clr = 4'b0001; @(negedge clk); int_clr = 0;
    chk("R11 clear", {int_raw, irq}, 0);

    // R4 read with END, then resume from slot 0 (R7)
    base = log_n;
    wslot(0, mk(0,0,0,0,0)); wslot(1, mk(1,1,1,0,0)); wslot(2, mk(2,3,0,0,0));
    wslot(3, mk(2,1,0,0,1)); wslot(4, mk(4,0,0,0,0));
    push(8'hA1);
    run();
    chk("R7 end keeps bus", bus_held, 1);
    chk("R7 end complete", int_raw, 4'b0001);
    chk("R4 rx count", rx_level, 4);
    chk("R4 ack drive", {log_ackd[base+2], log_ackd[base+3], log_ackd[base+4], log_ackd[base+5]}, 4'b0001);
    errs = 0;
    for (int k = 0; k < 4; k++) begin pop_byte(b); if (b != rd_byte(base+2+k)) errs++; end
    chk("R4 rx data order", errs, 0);
    done_of(4, d); chk("R2 end slot done", d, 1);
    base = log_n;
    wslot(0, mk(3,0,0,0,0));
    run();
    chk("R7 resume at slot0", {log_n - base, 32'(log_op[base])}, {32'd1, 32'd3});
    chk("R7 bus released", bus_held, 0);
    clr_all();

    // R8 zero counts
    base = log_n;
    wslot(0, mk(0,0,0,0,0)); wslot(1, mk(1,0,1,0,0)); wslot(2, mk(2,0,0,0,0));
    wslot(3, mk(3,0,0,0,0));
    run();
    chk("R8 no requests for zero counts", log_n - base, 2);
    done_of(1, d); chk("R8 zero write done", d, 1);
    done_of(2, d); chk("R8 zero read done", d, 1);
    clr_all();

    // R5 ack mismatch with check
    ack_level = 1; base = log_n;
    wslot(0, mk(0,0,0,0,0)); wslot(1, mk(1,2,1,0,0)); wslot(2, mk(3,0,0,0,0));
    push(8'h11); push(8'h22);
    run();
    chk("R5 ack error raw", int_raw, 4'b0010);
    chk("R5 stops after one byte", log_n - base, 2);
    done_of(1, d); chk("R5 slot not done", d, 0);
    done_of(2, d); chk("R5 stop not reached", d, 0);
    chk("R5 bus still held", bus_held, 1);
    chk("R5 one byte left", tx_level, 1);
    clr_all();
    chk("R12 fifo reset", tx_level, 0);

    // R6 ack check disabled
    base = log_n;
    wslot(1, mk(1,2,0,0,0));
    push(8'h33); push(8'h44);
    run();
    chk("R6 mismatch ignored", {int_raw, 32'(log_n - base)}, {4'b0001, 32'd4});
    ack_level = 0; clr_all();

    // R12 rx flush
    wslot(0, mk(0,0,0,0,0)); wslot(1, mk(2,3,0,0,0)); wslot(2, mk(3,0,0,0,0));
    run();
    chk("R12 rx filled", rx_level, 3);
    clr_all();
    chk("R12 rx flushed", rx_level, 0);

    // R9 timeout
    hang = 1; cfg_timeout = 16'd20;
    wslot(0, mk(0,0,0,0,0)); wslot(1, mk(3,0,0,0,0));
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    repeat (10) @(negedge clk);
    chk("R9 no early timeout", {busy, int_raw[2]}, 2'b10);
    repeat (30) @(negedge clk);
    chk("R9 timeout", {busy, bus_held, int_raw}, {2'b00, 4'b0100});
    hang = 0; cfg_timeout = 16'd200; clr_all();

    // R10 arbitration loss on the write byte, R11 masking
    int_en = 4'b0111; base = log_n; arb_at = base + 1;
    wslot(0, mk(0,0,0,0,0)); wslot(1, mk(1,1,1,0,0)); wslot(2, mk(3,0,0,0,0));
    push(8'h9C);
    run();
    chk("R10 arb raw", {int_raw, bus_held}, {4'b1000, 1'b0});
    chk("R11 masked", {int_stat, irq}, 0);
    arb_at = -1; int_en = 4'hF; clr_all();

    // random writes and reads
    for (int it = 0; it < 24; it++) begin
      n = 1 + int'($urandom % 31);
      base = log_n; errs = 0;
      wslot(0, mk(0,0,0,0,0));
      if ($urandom % 2) begin
        for (int k = 0; k < n; k++) begin exp[k] = 8'($urandom); push(exp[k]); end
        wslot(1, mk(1,n,1,0,0)); wslot(2, mk(3,0,0,0,0));
        run();
        for (int k = 0; k < n; k++)
          if (log_op[base+1+k] != 1 || log_data[base+1+k] != exp[k]) errs++;
        chk("R3 random write", errs, 0);
      end else begin
        wslot(1, mk(2,n-1,0,0,0)); wslot(2, mk(2,1,0,0,1)); wslot(3, mk(3,0,0,0,0));
        run();
        for (int k = 0; k < n; k++) begin
          pop_byte(b);
          if (b != rd_byte(base+1+k) || log_ackd[base+1+k] != (k == n-1)) errs++;
        end
        chk("R4 random read", errs, 0);
      end
      chk("R7 random complete", {int_raw, bus_held}, {4'b0001, 1'b0});
      clr_all();
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule